// File: doc/BRIEF.md
# Byte Permute and Sign Unit

This block is a registered data-movement stage for 128-bit vector operands. Each accepted request selects one of three functions. The shuffle function fills each destination byte from a table held in operand A, using the control byte in the same lane of operand B. The align function joins the two operands and extracts a byte-shifted window. The sign function negates, passes or zeroes each element of A, depending on the sign of the matching element of B.

A narrow mode restricts every function to the low 64 bits of the operands. In that mode the upper 64 bits of the result are always zero. A request is taken on a rising edge where `valid_in` is high, and its result appears on the next edge together with `valid_out`. Decode and operand fetch are handled upstream. The reset input is expected to be released in step with the clock by the surrounding logic.

Top module: `bperm_sign_unit`

## Requirements
- R1: Shuffle (op_sel 0, wide): for each result byte i, if bit 7 of control byte i of B is 1 the byte is 0x00; otherwise bits [3:0] of that control byte pick byte 0..15 of A, and bits [6:4] have no effect.
- R2: Shuffle, narrow: result bytes 0..7 are built as in R1, but only control bits [2:0] select among A bytes 0..7. Control bit 3 and the upper half of A have no effect.
- R3: Align (op_sel 1, wide): the 32-byte value {A, B} (B in bytes 0..15) is shifted right by shift_cnt bytes and its low 16 bytes are output, with zeros shifted in from above. A count of 32 or more gives all zero.
- R4: Align, narrow: the 16-byte value {A[63:0], B[63:0]} is shifted right by shift_cnt bytes and its low 8 bytes are output. A count of 16 or more gives zero in the low half.
- R5: Sign (op_sel 2): elem_sz 0, 1 and 2 give 8-, 16- and 32-bit elements (3 is treated as 32). Each result element is the two's complement of the A element when the B element is negative, a copy of the A element when B is positive, and zero when B is zero.
- R6: In sign mode, negating the most negative element value (for example 0x80 for 8-bit elements) wraps back to that same value.
- R7: With narrow high, result[127:64] is zero for every op_sel value.
- R8: op_sel 3 is reserved and produces an all-zero result.
- R9: result and valid_out update on the rising edge after valid_in is sampled high. While valid_in is low, valid_out is 0 on the next edge and result keeps its previous value.
- R10: While rst_n is low, result is zero and valid_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Request strobe; operands are sampled when high |
| op_sel | input | 2 | 0 shuffle, 1 align, 2 sign, 3 reserved |
| narrow | input | 1 | 64-bit mode when high |
| elem_sz | input | 2 | Sign element size: 0 byte, 1 16-bit, 2/3 32-bit |
| shift_cnt | input | 6 | Align byte shift count |
| opnd_a | input | 128 | Operand A (table / high half / data) |
| opnd_b | input | 128 | Operand B (controls / low half / signs) |
| valid_out | output | 1 | Result valid |
| result | output | 128 | Registered result |

## Verification
Every function has exactly one register between the operand ports and `result`. An accepted request is therefore due on the first rising edge after it is presented. The bench drives each request on a falling edge and compares `result` and `valid_out` on the next falling edge, after exactly one rising edge. For the hold case, `valid_in` is lowered and the operands are scrambled on one falling edge. The following falling edge must still show the previous result, with `valid_out` low.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int unsigned VEC_W = 128;
  localparam int unsigned CNT_W = 6;

  typedef enum logic [1:0] {
    OP_SHUF  = 2'd0,
    OP_ALIGN = 2'd1,
    OP_SIGN  = 2'd2,
    OP_RSVD  = 2'd3
  } bps_op_e;
endpackage

// File: rtl/bps_shuffle.sv
module bps_shuffle #(
  parameter int unsigned DATA_W = 128
) (
  input  logic [DATA_W-1:0] tbl,
  input  logic [DATA_W-1:0] ctl,
  input  logic              narrow,
  output logic [DATA_W-1:0] res
);
  localparam int unsigned NB = DATA_W / 8;
  localparam int unsigned IW = $clog2(NB);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [7:0]    cbyte;
    logic [IW-1:0] idx;
    assign cbyte = ctl[8*i +: 8];
    // narrow mode: drop top index bit so only the low half of the table is reachable
    always_comb begin
      idx = cbyte[IW-1:0];
      if (narrow) idx[IW-1] = 1'b0;
    end
    if (i < NB / 2) begin : g_low
      assign res[8*i +: 8] = cbyte[7] ? 8'h00 : tbl[8*idx +: 8];
    end else begin : g_high
      assign res[8*i +: 8] = (cbyte[7] || narrow) ? 8'h00 : tbl[8*idx +: 8];
    end
  end
endmodule

// File: rtl/bps_align.sv
module bps_align #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned CNT_W  = 6
) (
  input  logic [DATA_W-1:0] hi_op,
  input  logic [DATA_W-1:0] lo_op,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              narrow,
  output logic [DATA_W-1:0] res
);
  localparam int unsigned HW = DATA_W / 2;

  logic [2*DATA_W-1:0] joined;
  logic [2*DATA_W-1:0] shifted;

  // narrow: {zeros, hi[63:0], lo[63:0]} so zeros enter from above the 16-byte pair
  assign joined  = narrow ? {{DATA_W{1'b0}}, hi_op[HW-1:0], lo_op[HW-1:0]}
                          : {hi_op, lo_op};
  assign shifted = joined >> {cnt, 3'b000};
  assign res     = narrow ? {{HW{1'b0}}, shifted[HW-1:0]} : shifted[DATA_W-1:0];

  always_comb begin
    // R3
    if (!narrow && cnt >= CNT_W'(2 * DATA_W / 8)) begin
      far_shift_chk : assert (res == '0);
    end
  end
endmodule

// File: rtl/bps_sign.sv
module bps_sign #(
  parameter int unsigned DATA_W = 128
) (
  input  logic [DATA_W-1:0] a_op,
  input  logic [DATA_W-1:0] b_op,
  input  logic [1:0]        esz,
  input  logic              narrow,
  output logic [DATA_W-1:0] res
);
  localparam int unsigned NSZ = 3;
  localparam int unsigned HW  = DATA_W / 2;

  logic [NSZ-1:0][DATA_W-1:0] cand;
  logic [DATA_W-1:0]          picked;

  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int unsigned W  = 8 << k;
    localparam int unsigned NE = DATA_W / W;
    for (genvar e = 0; e < NE; e++) begin : g_elem
      logic [W-1:0] av;
      logic [W-1:0] bv;
      assign av = a_op[e*W +: W];
      assign bv = b_op[e*W +: W];
      assign cand[k][e*W +: W] = (bv == '0)  ? '0
                               : bv[W-1]     ? -av
                               :               av;
    end
  end

  always_comb begin
    unique case (esz)
      2'd0:    picked = cand[0];
      2'd1:    picked = cand[1];
      default: picked = cand[2];
    endcase
    res = narrow ? {{HW{1'b0}}, picked[HW-1:0]} : picked;
  end
endmodule

// File: rtl/bperm_sign_unit.sv
module bperm_sign_unit
  import bps_pkg::*;
#(
  parameter int unsigned DATA_W = VEC_W,
  parameter int unsigned SH_W   = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [1:0]        op_sel,
  input  logic              narrow,
  input  logic [1:0]        elem_sz,
  input  logic [SH_W-1:0]   shift_cnt,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              valid_out,
  output logic [DATA_W-1:0] result
);
  bps_op_e           op;
  logic [DATA_W-1:0] shuf_res, align_res, sign_res, comb_res;
  logic [DATA_W-1:0] res_d, res_q;
  logic              vld_d, vld_q;

  assign op = bps_op_e'(op_sel);

  bps_shuffle #(.DATA_W(DATA_W)) u_shuf (
    .tbl(opnd_a), .ctl(opnd_b), .narrow(narrow), .res(shuf_res)
  );

  bps_align #(.DATA_W(DATA_W), .CNT_W(SH_W)) u_align (
    .hi_op(opnd_a), .lo_op(opnd_b), .cnt(shift_cnt), .narrow(narrow), .res(align_res)
  );

  bps_sign #(.DATA_W(DATA_W)) u_sign (
    .a_op(opnd_a), .b_op(opnd_b), .esz(elem_sz), .narrow(narrow), .res(sign_res)
  );

  always_comb begin
    unique case (op)
      OP_SHUF:  comb_res = shuf_res;
      OP_ALIGN: comb_res = align_res;
      OP_SIGN:  comb_res = sign_res;
      default:  comb_res = '0;
    endcase
  end

  // next state: capture enable is valid_in
  always_comb begin
    vld_d = valid_in;
    res_d = valid_in ? comb_res : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign result    = res_q;
  assign valid_out = vld_q;

  // R9
  valid_lat_chk : assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  // R9
  result_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!valid_out && $stable(result)));
  // R7
  narrow_upper_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && narrow) |=> (result[DATA_W-1:DATA_W/2] == '0));
  // R8
  rsvd_op_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op_sel == 2'd3) |=> (result == '0));
  // R5
  sign_zero_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op_sel == 2'd2 && opnd_b == '0) |=> (result == '0));
endmodule

// File: tb/bperm_sign_unit_tb_top.sv
module bperm_sign_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid_in;
  logic [1:0]   op_sel;
  logic         narrow;
  logic [1:0]   elem_sz;
  logic [5:0]   shift_cnt;
  logic [127:0] opnd_a, opnd_b;
  logic         valid_out;
  logic [127:0] result;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bperm_sign_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_sel(op_sel),
    .narrow(narrow), .elem_sz(elem_sz), .shift_cnt(shift_cnt),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .valid_out(valid_out), .result(result)
  );

  function automatic logic [127:0] exp_shuf(logic [127:0] a, logic [127:0] b, bit nar);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] c = b[8*i +: 8];
      int idx = nar ? int'(c[2:0]) : int'(c[3:0]);
      if (!(nar && i >= 8) && !c[7]) r[8*i +: 8] = a[8*idx +: 8];
    end
    return r;
  endfunction

  function automatic logic [127:0] exp_align(logic [127:0] a, logic [127:0] b, int n, bit nar);
    logic [7:0]   cat [32];
    logic [127:0] r = '0;
    int nb = nar ? 16 : 32;
    for (int j = 0; j < nb / 2; j++) begin
      cat[j]          = b[8*j +: 8];
      cat[nb / 2 + j] = a[8*j +: 8];
    end
    for (int i = 0; i < nb / 2; i++)
      if (i + n < nb) r[8*i +: 8] = cat[i + n];
    return r;
  endfunction

  function automatic logic [127:0] exp_sign(logic [127:0] a, logic [127:0] b, int sz, bit nar);
    logic [127:0] r = '0;
    int w = (sz >= 2) ? 32 : (8 << sz);
    for (int e = 0; e < 128 / w; e++) begin
      logic [31:0] av = '0, bv = '0, ov = '0;
      for (int t = 0; t < w; t++) begin
        av[t] = a[e*w + t];
        bv[t] = b[e*w + t];
      end
      if (bv == 0)          ov = 0;
      else if (bv[w-1])     ov = (~av + 32'd1);
      else                  ov = av;
      if (!(nar && e * w >= 64))
        for (int t = 0; t < w; t++) r[e*w + t] = ov[t];
    end
    return r;
  endfunction

  function automatic logic [127:0] exp_any(int op, logic [127:0] a, logic [127:0] b,
                                            int sz, int n, bit nar);
    case (op)
      0:       return exp_shuf(a, b, nar);
      1:       return exp_align(a, b, n, nar);
      2:       return exp_sign(a, b, sz, nar);
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag, int op, bit nar, int sz, int n,
                        logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    valid_in = 1'b1; op_sel = 2'(op); narrow = nar; elem_sz = 2'(sz);
    shift_cnt = 6'(n); opnd_a = a; opnd_b = b;
    @(negedge clk);
    check(tag, result, exp_any(op, a, b, sz, n, nar));
    check({tag, " valid R9"}, {127'd0, valid_out}, 128'd1);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam logic [127:0] SEQ = 128'hFFEEDDCCBBAA99887766554433221100;

  initial begin
    logic [127:0] a, b, keep;
    void'($urandom(32'd7713));
    rst_n = 1'b0; valid_in = 1'b0; op_sel = '0; narrow = 1'b0; elem_sz = '0;
    shift_cnt = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 result in reset", result, '0);
    check("R10 valid in reset", {127'd0, valid_out}, '0);
    rst_n = 1'b1;

    // R1: reversal, zeroing bit, bits 6:4 ignored (0x7n behaves like 0x0n)
    run_op("R1 reverse", 0, 0, 0, 0, SEQ, 128'h000102030405060708090A0B0C0D0E0F);
    run_op("R1 clear/ignore", 0, 0, 0, 0, SEQ, 128'h80FF7F70_3C2B1A09_F0E1D2C3_B4A59687);
    // R2: narrow shuffle, bit 3 ignored
    run_op("R2 narrow", 0, 1, 0, 0, SEQ, 128'h01010101_01010101_0F08800E_7B0A0905);

    // R3: wide align corner counts
    a = rnd128(); b = rnd128();
    run_op("R3 cnt0", 1, 0, 0, 0, a, b);
    run_op("R3 cnt5", 1, 0, 0, 5, a, b);
    run_op("R3 cnt16", 1, 0, 0, 16, a, b);
    run_op("R3 cnt31", 1, 0, 0, 31, a, b);
    run_op("R3 cnt32", 1, 0, 0, 32, a, b);
    run_op("R3 cnt63", 1, 0, 0, 63, a, b);
    // R4: narrow align
    run_op("R4 cnt3", 1, 1, 0, 3, a, b);
    run_op("R4 cnt15", 1, 1, 0, 15, a, b);
    run_op("R4 cnt16", 1, 1, 0, 16, a, b);

    // R5: sign with mixed neg / pos / zero controls, each size
    a = SEQ;
    b = 128'h80_7F_00_01_FF_00_40_C0_00_00_80_00_00_01_FF_FF;
    run_op("R5 byte", 2, 0, 0, 0, a, b);
    run_op("R5 half", 2, 0, 1, 0, a, b);
    run_op("R5 word", 2, 0, 2, 0, a, b);
    run_op("R5 esz3", 2, 0, 3, 0, a, b);
    run_op("R5 zero ctl", 2, 0, 0, 0, a, '0);
    // R6: most negative wraps
    run_op("R6 byte", 2, 0, 0, 0, {16{8'h80}}, {16{8'hFF}});
    run_op("R6 half", 2, 0, 1, 0, {8{16'h8000}}, {8{16'h8001}});
    run_op("R6 word", 2, 0, 2, 0, {4{32'h80000000}}, {4{32'h80000000}});
    // R7: narrow sign and narrow ops clear upper half
    run_op("R7 sign narrow", 2, 1, 1, 0, rnd128(), rnd128());
    // R8: reserved op
    run_op("R8 rsvd", 3, 0, 0, 0, rnd128(), rnd128());
    run_op("R8 rsvd narrow", 3, 1, 2, 9, rnd128(), rnd128());

    // R9: hold while valid_in low
    run_op("R9 load", 0, 0, 0, 0, SEQ, 128'h0F0E0D0C0B0A09080706050403020100);
    keep = SEQ;
    @(negedge clk);
    valid_in = 1'b0; opnd_a = rnd128(); opnd_b = rnd128(); op_sel = 2'd1;
    @(negedge clk);
    check("R9 hold result", result, keep);
    check("R9 valid low", {127'd0, valid_out}, '0);

    // random mix covering R1 R2 R3 R4 R5 R7 R8
    for (int k = 0; k < 400; k++) begin
      int op = int'($urandom_range(0, 3));
      bit nar = 1'($urandom_range(0, 1));
      b = rnd128();
      for (int j = 0; j < 16; j++) if ($urandom_range(0, 3) == 0) b[8*j +: 8] = 8'h00;
      run_op("R1-R8 random", op, nar, int'($urandom_range(0, 3)),
             int'($urandom_range(0, 63)), rnd128(), b);
    end

    @(negedge clk);
    valid_in = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule